// File: doc/BRIEF.md
# Triggered Three-Range Peak Encoder

This block serves one detector channel that is digitised by three 10-bit converters at once, each after an amplifier of a different gain (x8, x1 and x0.25). All three sample streams run through a fixed delay so that a level-1 accept can still reach the samples of the event it selected. Once an accept is registered, the block scans a fixed window of delayed samples in all three ranges. It tracks the maximum and its position in each range, and it notes whether any sample reached full scale.

When the window closes, the block chooses the most sensitive range whose converter never clipped and builds a compact floating-point-like word. The exponent is a 2-bit range tag and the mantissa is the peak code of that range. The word is tagged with the trigger number and the peak position, and it is queued in a small output FIFO that is read through a valid/ready handshake.

Accepts that arrive while a window is open wait in a short queue. They are served back to back. The level-1 reset input returns the trigger bookkeeping to its initial state without touching the delay lines.

Top module: `tri_range_peak_encoder`

## Requirements
- R1: For an accept registered at clock edge E while no search is running or pending, the window is the WINDOW (50) samples presented at edges E-DELAY through E-DELAY+WINDOW-1, with DELAY = 64. Window position 0 is the sample from edge E-DELAY.
- R2: The mantissa is the largest code of the chosen range within the window. The index field is the 0-based window position of its first occurrence, so on a tie the earliest sample wins.
- R3: A range counts as saturated when any window sample equals 1023. The range code is 0 (x8) if that range is not saturated, otherwise 1 (x1) if that range is not saturated, otherwise 2 (x0.25). Code 3 never occurs, and a record with code 0 or 1 never carries mantissa 1023.
- R4: rec_data_o holds the trigger number in bits [25:18], the range code in [17:16], the peak index in [15:10] and the mantissa in [9:0].
- R5: Trigger numbers count accepts from 0 after either reset and wrap modulo 256. An accept lost to queue overflow still consumes a number.
- R6: For an isolated accept registered at edge E, rec_valid_o first rises after edge E+52, provided the FIFO is empty.
- R7: An accept that arrives during an open window is queued. Its window starts with the sample right after the last sample of the previous window, and its record is due exactly WINDOW cycles after the previous one.
- R8: At most 4 accepts may wait in the queue. A further accept is dropped and sets lost_err_o, which stays set until rst_ni. The level-1 reset does not clear it.
- R9: While rec_valid_o is high and rec_ready_i is low, rec_valid_o stays high and rec_data_o stays unchanged. Records leave in completion order.
- R10: A record completed while the output FIFO (depth 4) is full is discarded and sets lost_err_o.
- R11: An l1_reset_i pulse at edge E drives rec_valid_o low after E. It discards queued accepts, any open window and all buffered records, and the next accept receives trigger number 0.
- R12: After rst_ni, rec_valid_o and lost_err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| samp_x8_i | input | 10 | Sample of the x8 gain range |
| samp_x1_i | input | 10 | Sample of the x1 gain range |
| samp_xq_i | input | 10 | Sample of the x0.25 gain range |
| l1_accept_i | input | 1 | Level-1 accept, one cycle per trigger |
| l1_reset_i | input | 1 | Level-1 reset of trigger state |
| rec_valid_o | output | 1 | Output record available |
| rec_ready_i | input | 1 | Consumer takes the record |
| rec_data_o | output | 26 | Trigger number, range code, peak index, mantissa |
| lost_err_o | output | 1 | Sticky flag for a dropped accept or record |

## Verification
Accept handling takes two registers: the queue write and the pop that starts the search. The scan then takes 50 cycles, and one more register moves the finished record into the FIFO. An isolated record is therefore due 52 cycles after its accept edge, and each queued record is due 50 cycles after the one before it. The bench models this schedule, including the queue occupancy that decides when an accept overflows. It attaches a due cycle to every expected record, and the monitor compares the cycle counter with that due cycle whenever the consumer is ready. For the level-1 reset, the bench samples rec_valid_o one cycle after the pulse. Under backpressure, it samples the held record at several cycles spread across the stall.

// File: rtl/tre_pkg.sv
package tre_pkg;
  localparam int NUM_RANGES = 3;
  localparam int RNG_W      = 2;

  typedef enum logic [RNG_W-1:0] {
    RNG_X8 = 2'd0,
    RNG_X1 = 2'd1,
    RNG_XQ = 2'd2
  } range_e;
endpackage

// File: rtl/tre_delay_line.sv
module tre_delay_line #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 66
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (ptr_q == PTR_W'(DEPTH-1)) ptr_q <= '0;
    else ptr_q <= ptr_q + 1'b1;
  end

  // slot read before overwrite: value written DEPTH edges ago
  always_ff @(posedge clk_i) mem[ptr_q] <= data_i;

  assign data_o = mem[ptr_q];
endmodule

// File: rtl/tre_peak_track.sv
module tre_peak_track #(
  parameter int WIDTH = 10,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             first_i,
  input  logic [WIDTH-1:0] samp_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [WIDTH-1:0] peak_o,
  output logic [IDX_W-1:0] pidx_o,
  output logic             sat_o
);
  logic is_full;
  assign is_full = &samp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_o <= '0;
      pidx_o <= '0;
      sat_o  <= 1'b0;
    end else if (en_i) begin
      if (first_i) begin
        peak_o <= samp_i;
        pidx_o <= idx_i;
        sat_o  <= is_full;
      end else begin
        if (samp_i > peak_o) begin
          peak_o <= samp_i;
          pidx_o <= idx_i;
        end
        if (is_full) sat_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tre_fifo.sv
module tre_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign data_o  = mem[rd_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q] <= data_i;
  end
endmodule

// File: rtl/tri_range_peak_encoder.sv
module tri_range_peak_encoder
  import tre_pkg::*;
#(
  parameter int SAMP_W     = 10,
  parameter int DELAY      = 64,
  parameter int WINDOW     = 50,
  parameter int PEND_DEPTH = 4,
  parameter int OUT_DEPTH  = 4,
  parameter int TRIG_W     = 8
) (
  input  logic                                              clk_i,
  input  logic                                              rst_ni,
  input  logic [SAMP_W-1:0]                                 samp_x8_i,
  input  logic [SAMP_W-1:0]                                 samp_x1_i,
  input  logic [SAMP_W-1:0]                                 samp_xq_i,
  input  logic                                              l1_accept_i,
  input  logic                                              l1_reset_i,
  output logic                                              rec_valid_o,
  input  logic                                              rec_ready_i,
  output logic [TRIG_W+RNG_W+$clog2(WINDOW)+SAMP_W-1:0]     rec_data_o,
  output logic                                              lost_err_o
);
  localparam int IDX_W     = $clog2(WINDOW);
  localparam int TAP_DEPTH = DELAY + 2;  // covers accept queue write and search start
  localparam int REC_W     = TRIG_W + RNG_W + IDX_W + SAMP_W;

  // delay lines and per-range peak trackers
  logic [SAMP_W-1:0] samp_in  [NUM_RANGES];
  logic [SAMP_W-1:0] samp_dly [NUM_RANGES];
  logic [SAMP_W-1:0] peak     [NUM_RANGES];
  logic [IDX_W-1:0]  pidx     [NUM_RANGES];
  logic [NUM_RANGES-1:0] sat;

  assign samp_in[0] = samp_x8_i;
  assign samp_in[1] = samp_x1_i;
  assign samp_in[2] = samp_xq_i;

  logic             active_q;
  logic [IDX_W-1:0] cnt_q;
  logic             first_smp, last_smp;

  assign first_smp = active_q && (cnt_q == '0);
  assign last_smp  = active_q && (cnt_q == IDX_W'(WINDOW-1));

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_rng
    tre_delay_line #(
      .WIDTH (SAMP_W),
      .DEPTH (TAP_DEPTH)
    ) u_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .data_i (samp_in[g]),
      .data_o (samp_dly[g])
    );

    tre_peak_track #(
      .WIDTH (SAMP_W),
      .IDX_W (IDX_W)
    ) u_pk (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (active_q),
      .first_i (first_smp),
      .samp_i  (samp_dly[g]),
      .idx_i   (cnt_q),
      .peak_o  (peak[g]),
      .pidx_o  (pidx[g]),
      .sat_o   (sat[g])
    );
  end

  // trigger numbering and pending accepts
  logic [TRIG_W-1:0] trig_q;
  logic              pend_full, pend_empty;
  logic [TRIG_W-1:0] pend_head;
  logic              acc_push, acc_lost, start;

  assign acc_push = l1_accept_i && !l1_reset_i && !pend_full;
  assign acc_lost = l1_accept_i && !l1_reset_i && pend_full;
  assign start    = (!active_q || last_smp) && !pend_empty && !l1_reset_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          trig_q <= '0;
    else if (l1_reset_i)  trig_q <= '0;
    else if (l1_accept_i) trig_q <= trig_q + 1'b1;
  end

  tre_fifo #(
    .WIDTH (TRIG_W),
    .DEPTH (PEND_DEPTH)
  ) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (l1_reset_i),
    .push_i  (acc_push),
    .data_i  (trig_q),
    .pop_i   (start),
    .data_o  (pend_head),
    .empty_o (pend_empty),
    .full_o  (pend_full)
  );

  // window sequencing
  logic [TRIG_W-1:0] cur_trig_q, done_trig_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      cnt_q       <= '0;
      cur_trig_q  <= '0;
      done_q      <= 1'b0;
      done_trig_q <= '0;
    end else if (l1_reset_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_smp;
      if (last_smp) done_trig_q <= cur_trig_q;
      if (start) begin
        active_q   <= 1'b1;
        cnt_q      <= '0;
        cur_trig_q <= pend_head;
      end else if (last_smp) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // range choice and record packing
  range_e            sel;
  logic [SAMP_W-1:0] sel_peak;
  logic [IDX_W-1:0]  sel_idx;
  logic [REC_W-1:0]  rec_word;

  always_comb begin
    if (!sat[0])      sel = RNG_X8;
    else if (!sat[1]) sel = RNG_X1;
    else              sel = RNG_XQ;
    case (sel)
      RNG_X8:  begin sel_peak = peak[0]; sel_idx = pidx[0]; end
      RNG_X1:  begin sel_peak = peak[1]; sel_idx = pidx[1]; end
      default: begin sel_peak = peak[2]; sel_idx = pidx[2]; end
    endcase
  end

  assign rec_word = {done_trig_q, sel, sel_idx, sel_peak};

  // output buffer
  logic out_full, out_empty, rec_drop;

  assign rec_drop = done_q && out_full && !l1_reset_i;

  tre_fifo #(
    .WIDTH (REC_W),
    .DEPTH (OUT_DEPTH)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (l1_reset_i),
    .push_i  (done_q),
    .data_i  (rec_word),
    .pop_i   (rec_ready_i),
    .data_o  (rec_data_o),
    .empty_o (out_empty),
    .full_o  (out_full)
  );

  assign rec_valid_o = !out_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   lost_err_o <= 1'b0;
    else if (acc_lost || rec_drop) lost_err_o <= 1'b1;
  end
endmodule

// File: rtl/tre_checker.sv
module tre_checker #(
  parameter int SAMP_W = 10,
  parameter int IDX_W  = 6,
  parameter int WINDOW = 50,
  parameter int REC_W  = 26
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             l1_reset_i,
  input logic             rec_valid_o,
  input logic             rec_ready_i,
  input logic [REC_W-1:0] rec_data_o,
  input logic             lost_err_o
);
  logic [1:0]        f_rng;
  logic [IDX_W-1:0]  f_idx;
  logic [SAMP_W-1:0] f_mant;

  assign f_mant = rec_data_o[SAMP_W-1:0];
  assign f_idx  = rec_data_o[SAMP_W +: IDX_W];
  assign f_rng  = rec_data_o[SAMP_W+IDX_W +: 2];

  p_code_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> f_rng != 2'd3);

  p_unsat_pick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && f_rng != 2'd2) |-> f_mant != {SAMP_W{1'b1}});

  p_idx_in_win_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> int'(f_idx) < WINDOW);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !rec_ready_i && !l1_reset_i) |=> (rec_valid_o && $stable(rec_data_o)));

  p_flush_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_reset_i |=> !rec_valid_o);

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_err_o |=> lost_err_o);
endmodule

bind tri_range_peak_encoder tre_checker #(
  .SAMP_W (SAMP_W),
  .IDX_W  (IDX_W),
  .WINDOW (WINDOW),
  .REC_W  (REC_W)
) u_tre_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .l1_reset_i  (l1_reset_i),
  .rec_valid_o (rec_valid_o),
  .rec_ready_i (rec_ready_i),
  .rec_data_o  (rec_data_o),
  .lost_err_o  (lost_err_o)
);

// File: tb/tri_range_peak_encoder_bench.sv
module tri_range_peak_encoder_bench;
  localparam int SW = 10, DLY = 64, WIN = 50, TW = 8, IW = 6;
  localparam int RW = TW + 2 + IW + SW;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [SW-1:0] s8 = '0, s1 = '0, sq = '0;
  logic          acc = 1'b0, l1r = 1'b0, rdy = 1'b1;
  logic          vld, err;
  logic [RW-1:0] rdata;

  always #10 clk = ~clk;

  tri_range_peak_encoder u_tri_range_peak_encoder (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .samp_x8_i   (s8),
    .samp_x1_i   (s1),
    .samp_xq_i   (sq),
    .l1_accept_i (acc),
    .l1_reset_i  (l1r),
    .rec_valid_o (vld),
    .rec_ready_i (rdy),
    .rec_data_o  (rdata),
    .lost_err_o  (err)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // stimulus: pulses over a small baseline
  int pc[$], pa[$], pw[$];

  function automatic int sig(input int n);
    int s, d, v;
    s = 4 + (n % 3);
    foreach (pc[i]) begin
      d = (n > pc[i]) ? n - pc[i] : pc[i] - n;
      v = 0;
      if (d <= pw[i]) v = pa[i];
      else if (d < pw[i] + 10) v = pa[i] * (pw[i] + 10 - d) / 10;
      if (v > s) s = v;
    end
    return s;
  endfunction

  function automatic int rng_val(input int s, input int r);
    int v;
    v = (r == 0) ? s : (r == 1) ? s / 8 : s / 32;
    return (v > 1023) ? 1023 : v;
  endfunction

  always @(negedge clk) begin
    s8 <= SW'(rng_val(sig(cyc + 1), 0));
    s1 <= SW'(rng_val(sig(cyc + 1), 1));
    sq <= SW'(rng_val(sig(cyc + 1), 2));
  end

  function automatic logic [RW-1:0] expect_rec(input int s_edge, input int trig);
    int e0, r, v;
    int pk[3];
    int ix[3];
    bit st[3];
    e0 = s_edge - DLY - 2;
    for (int k = 0; k < 3; k++) begin
      pk[k] = -1; ix[k] = 0; st[k] = 0;
      for (int j = 0; j < WIN; j++) begin
        v = rng_val(sig(e0 + j), k);
        if (v == 1023) st[k] = 1;
        if (v > pk[k]) begin pk[k] = v; ix[k] = j; end
      end
    end
    r = !st[0] ? 0 : (!st[1] ? 1 : 2);
    return {TW'(trig), 2'(r), IW'(ix[r]), SW'(pk[r])};
  endfunction

  // scoreboard
  logic [RW-1:0] exp_d[$];
  int            exp_due[$];
  string         exp_tag[$];
  int            sched_s[$];
  int            last_l = -1000;
  int            trig_n = 0;

  task automatic model_clear();
    sched_s.delete();
    exp_d.delete(); exp_due.delete(); exp_tag.delete();
    last_l = -1000;
    trig_n = 0;
  endtask

  // accept at edge a; keep = record expected to reach the consumer; timed = due check
  task automatic fire(input int a, input bit keep, input bit timed, input string tag);
    int occ, s;
    while (cyc < a - 1) @(negedge clk);
    acc = 1'b1;
    occ = 0;
    foreach (sched_s[i]) if (sched_s[i] - 1 >= a) occ++;
    if (occ < 4) begin
      s = (a + 2 > last_l + 1) ? a + 2 : last_l + 1;
      last_l = s + WIN - 1;
      sched_s.push_back(s);
      if (keep) begin
        exp_d.push_back(expect_rec(s, trig_n));
        exp_due.push_back(timed ? s + WIN : -1);
        exp_tag.push_back(tag);
      end
    end
    trig_n++;
    @(negedge clk);
    acc = 1'b0;
  endtask

  task automatic pulse_fire(input int amp, input int plat, input int jpos, input string tag);
    int a;
    a = cyc + DLY + 10;
    pc.push_back(a - DLY + jpos); pa.push_back(amp); pw.push_back(plat);
    fire(a, 1'b1, 1'b1, tag);
  endtask

  task automatic wait_idle();
    while (exp_d.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic do_rst();
    rst_n = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    chk(vld == 1'b0, "R12", "valid in reset", vld, 0);
    chk(err == 1'b0, "R12", "error flag in reset", err, 0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
  endtask

  task automatic l1_pulse();
    l1r = 1'b1;
    model_clear();
    @(negedge clk);
    l1r = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && vld && rdy) begin
      if (exp_d.size() == 0) begin
        chk(1'b0, "R9", "unexpected record", rdata, 0);
      end else begin
        logic [RW-1:0] d;
        int du;
        string tg;
        d = exp_d.pop_front(); du = exp_due.pop_front(); tg = exp_tag.pop_front();
        chk(rdata == d, tg, "record", rdata, d);
        if (du >= 0) chk(cyc == du, "R6 R7", "record due cycle", cyc, du);
      end
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R6 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int a0;
    @(negedge clk);
    do_rst();

    // range selection, peak position and window alignment
    pulse_fire(300, 0, 20, "R1 R2 R3 R4 R5 x8 range"); wait_idle();
    pulse_fire(3000, 0, 25, "R3 x1 range");           wait_idle();
    pulse_fire(20000, 1, 30, "R3 xq range");          wait_idle();
    pulse_fire(40000, 0, 15, "R3 all saturated");     wait_idle();
    pulse_fire(1023, 2, 22, "R2 R3 x8 at full scale"); wait_idle();
    pulse_fire(1022, 3, 18, "R2 R3 x8 just below full scale"); wait_idle();
    pulse_fire(500, 0, 0, "R1 R2 window first sample"); wait_idle();
    pulse_fire(500, 0, WIN - 1, "R1 R2 window last sample"); wait_idle();

    // queued accepts and overflow
    chk(err == 1'b0, "R8", "error flag before burst", err, 0);
    a0 = cyc + DLY + 10;
    pc.push_back(a0 - DLY + 10); pa.push_back(800); pw.push_back(0);
    for (int k = 0; k < 6; k++) fire(a0 + k, 1'b1, 1'b1, "R5 R7 queued record");
    wait_idle();
    chk(err == 1'b1, "R8", "error flag after overflow", err, 1);
    pulse_fire(200, 0, 5, "R5 number after dropped accept"); wait_idle();
    l1_pulse();
    @(negedge clk);
    chk(err == 1'b1, "R8", "error flag after level-1 reset", err, 1);
    do_rst();

    // backpressure and full output buffer
    rdy = 1'b0;
    a0 = cyc + DLY + 10;
    for (int k = 0; k < 5; k++) begin
      pc.push_back(a0 + 60 * k - DLY + 10 + k); pa.push_back(100 + 50 * k); pw.push_back(0);
      fire(a0 + 60 * k, k < 4, 1'b0, "R9 R10 ordered record");
      if (k == 1) begin
        chk(vld == 1'b1, "R9", "valid held", vld, 1);
        chk(rdata == exp_d[0], "R9", "data held", rdata, exp_d[0]);
      end
    end
    while (cyc < a0 + 60 * 4 + 60) @(negedge clk);
    chk(vld == 1'b1, "R9", "valid held late", vld, 1);
    chk(rdata == exp_d[0], "R9", "data held late", rdata, exp_d[0]);
    chk(err == 1'b1, "R10", "error flag after full buffer drop", err, 1);
    rdy = 1'b1;
    wait_idle();
    do_rst();

    // level-1 reset during an open window
    a0 = cyc + DLY + 10;
    fire(a0, 1'b0, 1'b0, "R11");
    while (cyc < a0 + 20) @(negedge clk);
    l1_pulse();
    repeat (60) @(negedge clk);
    chk(vld == 1'b0, "R11", "no record after reset mid-window", vld, 0);
    pulse_fire(400, 0, 12, "R5 R11 number restarts"); wait_idle();

    // level-1 reset flushes a buffered record
    rdy = 1'b0;
    a0 = cyc + DLY + 10;
    fire(a0, 1'b0, 1'b0, "R11");
    while (cyc < a0 + 54) @(negedge clk);
    chk(vld == 1'b1, "R6", "record buffered", vld, 1);
    l1_pulse();
    chk(vld == 1'b0, "R11", "valid after level-1 reset", vld, 0);
    rdy = 1'b1;
    repeat (10) @(negedge clk);
    chk(vld == 1'b0, "R11", "buffer stays empty", vld, 0);

    chk(exp_d.size() == 0, "R9", "outstanding records", exp_d.size(), 0);
    summary();
    $finish;
  end
endmodule